// File: doc/BRIEF.md
# Length-Steered Serial Register Port

This block is a three-wire serial slave (serial clock, serial data in, active-low enable) that fills three held registers without any address bits. While the enable is low, each rising edge of the serial clock shifts one data bit into a shift chain, most significant bit first, and a saturating counter tracks how many clocks arrived. When the enable returns high, the clock count alone picks the destination. Eight clocks load an 8-bit configuration register. Sixteen clocks load a 16-bit feedback divide register. Fifteen or twenty-four clocks load a 15-bit reference divide register. Nine to thirteen clocks trigger a soft reset. Every other length is dropped.

The serial pins are brought into the system clock domain through synchronizers, and all edges are detected there. A serial data output replays the chain sixteen and a half stages late, so a host can read its own stream back. Next to it is a pad-enable output that asks for high impedance while the port is idle. A divider block downstream uses the one-cycle `n_written` strobe to reload its counters.

Top module: `lsp_serial_port`

## Requirements
- R1: Data is taken most significant bit first, one bit per rising edge of the serial clock while the port is enabled.
- R2: A transfer of exactly 8 clocks loads `cfg_q` with the 8 bits sent. No other register changes.
- R3: A transfer of exactly 16 clocks loads `n_q` with the 16 bits sent. `n_written` is then high for exactly one system clock cycle.
- R4: A transfer of 15 or 24 clocks loads `r_q` with the last 15 bits shifted in.
- R5: A transfer of 9 to 13 clocks pulses `soft_reset` for one cycle. It also returns all three registers to their power-on values.
- R6: Any other length up to 32 writes nothing. The clock counter saturates at 33, so lengths above 32 (for example 40, 47, 48, 56 or 64) also write nothing.
- R7: The held registers keep their values during shifting. They change only when the enable rises.
- R8: While the enable is high, no bits are shifted, the clock counter is held at zero, `ser_dout_oe` is 0 and `ser_dout` is 0.
- R9: While enabled, `ser_dout` changes on falling serial clock edges. After the falling edge that follows rising edge k (k ≥ 16), it shows the bit taken at rising edge k−15.
- R10: After reset, `cfg_q` is 0x10 and `n_q` and `r_q` are 0. The 0x10 value decodes as follows: bit 7 polarity = 0, bit 6 detector select = 0, bit 5 lock-detect enable = 0, bits 4:2 reference output select = 100 (divide by 8), bit 1 feedback output enable = 0, bit 0 reference output enable = 0.
- R11: An enable edge that arrives while the serial clock is high takes effect only once the serial clock is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_din | input | 1 | Serial data in |
| ser_en_n | input | 1 | Active-low transfer enable |
| ser_dout | output | 1 | Serial data out, delayed chain |
| ser_dout_oe | output | 1 | Pad drive enable for ser_dout (0 = high impedance) |
| cfg_q | output | 8 | Held configuration register |
| n_q | output | 16 | Held feedback divide register |
| r_q | output | 15 | Held reference divide register |
| n_written | output | 1 | One-cycle strobe after an N load |
| soft_reset | output | 1 | One-cycle strobe after a reset-length transfer |

## Verification
The assertions assume that each serial clock level and each data value lasts several system clocks. Under that assumption the synchronized clock and data arrive together, and no serial edge is lost between samples. The bench holds every serial half period for four system clocks. It changes data only while the serial clock is low and is settled. It moves the enable only while the serial clock is low, except in the one case that deliberately raises the enable during a high clock to exercise the deferred commit.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
   typedef enum logic [2:0] {
      DEST_NONE,
      DEST_CFG,
      DEST_N,
      DEST_R,
      DEST_RESET
   } dest_e;
endpackage

// File: rtl/lsp_sync.sv
module lsp_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("lsp_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0] stage;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage <= {STAGES{RESET_VAL}};
         else if (STAGES == 1) stage <= d;
         else stage <= {stage[STAGES-2:0], d};
      end
      assign q = stage[STAGES-1];
   end
endmodule

// File: rtl/lsp_shifter.sv
module lsp_shifter #(
   parameter int CHAIN_W  = 16,
   parameter int CNT_W    = 6,
   parameter int CNT_SAT  = 33,
   parameter int DOUT_TAP = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk,
   input  logic               din,
   input  logic               en_n,
   output logic [CHAIN_W-1:0] chain,
   output logic [CNT_W-1:0]   bit_cnt,
   output logic               commit,
   output logic               en_gate,
   output logic               dout,
   output logic               dout_oe
);
   logic sclk_d;
   logic sclk_rise, sclk_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk;
   end

   assign sclk_rise = sclk & ~sclk_d;
   assign sclk_fall = ~sclk & sclk_d;

   // enable is only sampled while the serial clock is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_gate <= 1'b1;
      else if (!sclk) en_gate <= en_n;
   end

   assign commit  = ~sclk & en_n & ~en_gate;
   assign dout_oe = ~en_gate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bit_cnt <= '0;
      else if (en_gate)
         bit_cnt <= '0;
      else if (sclk_rise && bit_cnt != CNT_W'(CNT_SAT))
         bit_cnt <= bit_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain <= '0;
      else if (!en_gate && sclk_rise)
         chain <= {chain[CHAIN_W-2:0], din};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout <= 1'b0;
      else if (en_gate)
         dout <= 1'b0;
      else if (sclk_fall)
         dout <= chain[DOUT_TAP-1];
   end
endmodule

// File: rtl/lsp_dispatch.sv
module lsp_dispatch
   import lsp_pkg::*;
#(
   parameter int         CHAIN_W    = 16,
   parameter int         CNT_W      = 6,
   parameter int         CFG_W      = 8,
   parameter int         N_W        = 16,
   parameter int         R_W        = 15,
   parameter int         R_LONG_LEN = 24,
   parameter int         RST_MIN    = 9,
   parameter int         RST_MAX    = 13,
   parameter logic [7:0] CFG_INIT   = 8'h10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit,
   input  logic [CNT_W-1:0]   bit_cnt,
   input  logic [CHAIN_W-1:0] chain,
   output logic [CFG_W-1:0]   cfg_q,
   output logic [N_W-1:0]     n_q,
   output logic [R_W-1:0]     r_q,
   output logic               n_written,
   output logic               soft_reset
);
   dest_e dest;

   always_comb begin
      if (bit_cnt == CNT_W'(CFG_W))
         dest = DEST_CFG;
      else if (bit_cnt == CNT_W'(N_W))
         dest = DEST_N;
      else if (bit_cnt == CNT_W'(R_W) || bit_cnt == CNT_W'(R_LONG_LEN))
         dest = DEST_R;
      else if (bit_cnt >= CNT_W'(RST_MIN) && bit_cnt <= CNT_W'(RST_MAX))
         dest = DEST_RESET;
      else
         dest = DEST_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= CFG_W'(CFG_INIT);
         n_q        <= '0;
         r_q        <= '0;
         n_written  <= 1'b0;
         soft_reset <= 1'b0;
      end else begin
         n_written  <= 1'b0;
         soft_reset <= 1'b0;
         if (commit) begin
            case (dest)
               DEST_CFG: cfg_q <= chain[CFG_W-1:0];
               DEST_N: begin
                  n_q       <= chain[N_W-1:0];
                  n_written <= 1'b1;
               end
               DEST_R: r_q <= chain[R_W-1:0];
               DEST_RESET: begin
                  cfg_q      <= CFG_W'(CFG_INIT);
                  n_q        <= '0;
                  r_q        <= '0;
                  soft_reset <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/lsp_serial_port.sv
module lsp_serial_port #(
   parameter int         CFG_W       = 8,
   parameter int         N_W         = 16,
   parameter int         R_W         = 15,
   parameter int         R_LONG_LEN  = 24,
   parameter int         RST_MIN     = 9,
   parameter int         RST_MAX     = 13,
   parameter int         LEN_MAX     = 32,
   parameter int         SYNC_STAGES = 2,
   parameter int         DOUT_TAP    = 16,
   parameter logic [7:0] CFG_INIT    = 8'h10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_clk,
   input  logic             ser_din,
   input  logic             ser_en_n,
   output logic             ser_dout,
   output logic             ser_dout_oe,
   output logic [CFG_W-1:0] cfg_q,
   output logic [N_W-1:0]   n_q,
   output logic [R_W-1:0]   r_q,
   output logic             n_written,
   output logic             soft_reset
);
   localparam int CNT_SAT = LEN_MAX + 1;
   localparam int CNT_W   = $clog2(CNT_SAT + 1);
   localparam int WIDEST  = (N_W > R_W) ? N_W : R_W;
   localparam int CHAIN_W = (WIDEST > DOUT_TAP) ? WIDEST : DOUT_TAP;

   if (CFG_W > CHAIN_W || R_LONG_LEN > LEN_MAX || N_W > LEN_MAX) begin : g_bad_len
      $error("lsp_serial_port: register lengths exceed chain or LEN_MAX");
   end
   if (RST_MIN > RST_MAX || DOUT_TAP < 1) begin : g_bad_misc
      $error("lsp_serial_port: bad reset window or output tap");
   end

   logic s_clk, s_din, s_en_n;

   lsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(s_clk));
   lsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_din (
      .clk(clk), .rst_n(rst_n), .d(ser_din), .q(s_din));
   lsp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_en (
      .clk(clk), .rst_n(rst_n), .d(ser_en_n), .q(s_en_n));

   logic [CHAIN_W-1:0] chain;
   logic [CNT_W-1:0]   bit_cnt;
   logic               commit;
   logic               en_gate;

   lsp_shifter #(
      .CHAIN_W(CHAIN_W), .CNT_W(CNT_W), .CNT_SAT(CNT_SAT), .DOUT_TAP(DOUT_TAP)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .sclk(s_clk), .din(s_din), .en_n(s_en_n),
      .chain(chain), .bit_cnt(bit_cnt), .commit(commit), .en_gate(en_gate),
      .dout(ser_dout), .dout_oe(ser_dout_oe));

   lsp_dispatch #(
      .CHAIN_W(CHAIN_W), .CNT_W(CNT_W), .CFG_W(CFG_W), .N_W(N_W), .R_W(R_W),
      .R_LONG_LEN(R_LONG_LEN), .RST_MIN(RST_MIN), .RST_MAX(RST_MAX),
      .CFG_INIT(CFG_INIT)
   ) u_disp (
      .clk(clk), .rst_n(rst_n), .commit(commit), .bit_cnt(bit_cnt),
      .chain(chain), .cfg_q(cfg_q), .n_q(n_q), .r_q(r_q),
      .n_written(n_written), .soft_reset(soft_reset));
endmodule

// File: rtl/lsp_serial_port_chk.sv
module lsp_serial_port_chk #(
   parameter int         CFG_W    = 8,
   parameter int         N_W      = 16,
   parameter int         R_W      = 15,
   parameter int         CNT_W    = 6,
   parameter int         CNT_SAT  = 33,
   parameter logic [7:0] CFG_INIT = 8'h10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             commit,
   input logic             en_gate,
   input logic [CNT_W-1:0] bit_cnt,
   input logic [CFG_W-1:0] cfg_q,
   input logic [N_W-1:0]   n_q,
   input logic [R_W-1:0]   r_q,
   input logic             n_written,
   input logic             soft_reset
);
   a_r7_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(cfg_q) && $stable(n_q) && $stable(r_q)));

   a_r3_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      n_written |=> !n_written);

   a_r3_strobe_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
      n_written |-> $past(commit));

   a_r5_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
      soft_reset |-> (cfg_q == CFG_W'(CFG_INIT) && n_q == '0 && r_q == '0));

   a_r8_idle_count_zero: assert property (@(posedge clk) disable iff (!rst_n)
      en_gate |=> (bit_cnt == '0));

   a_r6_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(CNT_SAT));

   a_r5_no_double_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(soft_reset && n_written));
endmodule

bind lsp_serial_port lsp_serial_port_chk #(
   .CFG_W(CFG_W), .N_W(N_W), .R_W(R_W), .CNT_W(CNT_W), .CNT_SAT(CNT_SAT),
   .CFG_INIT(CFG_INIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .commit(commit), .en_gate(en_gate),
   .bit_cnt(bit_cnt), .cfg_q(cfg_q), .n_q(n_q), .r_q(r_q),
   .n_written(n_written), .soft_reset(soft_reset));

// File: tb/lsp_serial_port_test.sv
module lsp_serial_port_test;
   localparam int H = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_din = 1'b0, ser_en_n = 1'b1;
   logic ser_dout, ser_dout_oe;
   logic [7:0]  cfg_q;
   logic [15:0] n_q;
   logic [14:0] r_q;
   logic n_written, soft_reset;

   int tests = 0, fails = 0;
   int nw_seen = 0, sr_seen = 0;
   int cyc = 0;
   logic [7:0]  m_cfg = 8'h10;
   logic [15:0] m_n = '0;
   logic [14:0] m_r = '0;

   always #10 clk = ~clk;

   lsp_serial_port uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
      .ser_en_n(ser_en_n), .ser_dout(ser_dout), .ser_dout_oe(ser_dout_oe),
      .cfg_q(cfg_q), .n_q(n_q), .r_q(r_q), .n_written(n_written),
      .soft_reset(soft_reset));

   always @(negedge clk) begin
      if (rst_n && n_written)  nw_seen++;
      if (rst_n && soft_reset) sr_seen++;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         tests++; fails++;
         $display("FAIL watchdog: run hung, got %0d cycles exp < 150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h exp %h", tag, got, exp);
      end
   endtask

   function automatic string tag_of(input int len);
      if (len == 8) return "R2";
      if (len == 16) return "R3";
      if (len == 15 || len == 24) return "R4";
      if (len >= 9 && len <= 13) return "R5";
      return "R6";
   endfunction

   task automatic model(input int len, input logic [63:0] p,
                        output int nw_exp, output int sr_exp);
      nw_exp = 0; sr_exp = 0;
      if (len == 8) m_cfg = p[7:0];
      else if (len == 16) begin m_n = p[15:0]; nw_exp = 1; end
      else if (len == 15 || len == 24) m_r = p[14:0];
      else if (len >= 9 && len <= 13) begin
         m_cfg = 8'h10; m_n = '0; m_r = '0; sr_exp = 1;
      end
   endtask

   task automatic xfer(input int len, input logic [63:0] p);
      ser_en_n = 1'b0;
      wait_cyc(3 * H);
      chk("R8 oe while enabled", {31'b0, ser_dout_oe}, 32'd1);
      for (int k = 1; k <= len; k++) begin
         ser_din = p[len-k];
         wait_cyc(H);
         ser_clk = 1'b1;
         wait_cyc(H);
         if (k == (len + 1) / 2) begin
            chk("R7 cfg mid-shift", {24'b0, cfg_q}, {24'b0, m_cfg});
            chk("R7 n mid-shift", {16'b0, n_q}, {16'b0, m_n});
            chk("R7 r mid-shift", {17'b0, r_q}, {17'b0, m_r});
         end
         ser_clk = 1'b0;
         wait_cyc(H);
         if (k >= 16)
            chk("R9 dout replay", {31'b0, ser_dout}, {31'b0, p[len-(k-15)]});
      end
      ser_en_n = 1'b1;
      wait_cyc(3 * H);
   endtask

   task automatic run_len(input int len, input logic [63:0] p);
      int nw0, sr0, nw_exp, sr_exp;
      string t;
      t = tag_of(len);
      nw0 = nw_seen; sr0 = sr_seen;
      xfer(len, p);
      model(len, p, nw_exp, sr_exp);
      chk({t, " cfg"}, {24'b0, cfg_q}, {24'b0, m_cfg});
      chk({t, " n"}, {16'b0, n_q}, {16'b0, m_n});
      chk({t, " r"}, {17'b0, r_q}, {17'b0, m_r});
      chk({t, " n_written pulses (R3)"}, 32'(nw_seen - nw0), 32'(nw_exp));
      chk({t, " soft_reset pulses (R5)"}, 32'(sr_seen - sr0), 32'(sr_exp));
      chk("R8 oe idle", {31'b0, ser_dout_oe}, 32'd0);
      chk("R8 dout idle", {31'b0, ser_dout}, 32'd0);
   endtask

   function automatic logic [63:0] pat_of(input int len);
      logic [31:0] a, b;
      a = 32'(len) * 32'h9E3779B1 + 32'h1234ABCD;
      b = (32'(len) * 32'h85EBCA6B) ^ 32'h5A5AC3C3;
      return {a, b};
   endfunction

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(4);
      // R10 power-on state
      chk("R10 cfg reset", {24'b0, cfg_q}, 32'h10);
      chk("R10 n reset", {16'b0, n_q}, 32'h0);
      chk("R10 r reset", {17'b0, r_q}, 32'h0);
      chk("R8 oe reset", {31'b0, ser_dout_oe}, 32'd0);

      // R1: MSB first
      run_len(8, 64'h80);
      chk("R1 msb first", {24'b0, cfg_q}, 32'h80);

      // R8: clocks while disabled do not shift or count
      for (int i = 0; i < 20; i++) begin
         ser_din = i[0];
         ser_clk = 1'b1; wait_cyc(H);
         ser_clk = 1'b0; wait_cyc(H);
      end
      chk("R8 idle clocks no write", {24'b0, cfg_q}, 32'h80);
      run_len(16, 64'hBEEF);
      chk("R8 counter was zero", {16'b0, n_q}, 32'hBEEF);

      // length sweep, including the saturation cases
      for (int len = 1; len <= 34; len++) run_len(len, pat_of(len));
      run_len(40, pat_of(40));
      run_len(47, pat_of(47));
      run_len(48, pat_of(48));
      run_len(56, pat_of(56));
      run_len(64, pat_of(64));
      run_len(24, 64'hABCDEF);
      chk("R4 last 15 of 24", {17'b0, r_q}, 32'h4DEF);

      // R11: enable rises while the serial clock is high
      ser_en_n = 1'b0;
      wait_cyc(3 * H);
      for (int k = 1; k <= 8; k++) begin
         ser_din = 1'(8'h5C >> (8 - k));
         wait_cyc(H);
         ser_clk = 1'b1;
         wait_cyc(H);
         if (k < 8) begin ser_clk = 1'b0; wait_cyc(H); end
      end
      ser_en_n = 1'b1;
      wait_cyc(4 * H);
      chk("R11 deferred while clk high", {24'b0, cfg_q}, {24'b0, m_cfg});
      ser_clk = 1'b0;
      wait_cyc(3 * H);
      m_cfg = 8'h5C;
      chk("R11 commit after clk low", {24'b0, cfg_q}, 32'h5C);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule